// File: doc/BRIEF.md
# Sliding-Window Bin Width Estimator

This block keeps a running histogram over the most recent `DEPTH` fine-time tags produced by a two-line delay-line time converter. The histogram feeds code-density calibration. Each tag is `TAG_W` bits wide: the top bit names the delay line that measured the event, and the lower bits hold that line's fine code. The histogram therefore holds two banks of bins, one per delay line. Each bin's count is proportional to the width of that bin. With a reference period `T`, a count of `n` stands for a width of `n·T/DEPTH`. For example, with a window of 20,000 entries and a 2,500 ps period, a count of 256 stands for 32 ps.

Accepted tags enter a circular buffer and raise the count of their own bin. Once the buffer holds `DEPTH` tags, each new tag also removes the oldest tag in the same cycle, and the count of that tag's bin falls by one. The window therefore always covers the latest `DEPTH` events.

A separate counter tracks how many tags in the window carry a set line-select bit. That count gives an estimate of the reference clock's duty cycle. Pulling `enable` low freezes every estimate, which turns continuous calibration into fixed calibration. The estimates should only be trusted once `window_full` is high.

Top module: `tdc_bin_window`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, every bin count and `duty_count` is zero and `window_full` is low.
- R2: A tag accepted at a clock edge (`enable` and `tag_valid` both high) raises the count of bin `tag` by one. Bin `b` occupies `bin_counts[b*CNT_W +: CNT_W]`, where `CNT_W = $clog2(DEPTH+1)`. Bins 0 to 127 belong to the line with select bit 0, and bins 128 to 255 to the line with select bit 1. The new value is visible after that edge.
- R3: `window_full` goes high right after the edge that accepts the `DEPTH`-th tag since reset. It is low before that edge and stays high until the next reset.
- R4: While `window_full` is high, each accepted tag also removes the oldest tag in the window: the count of the oldest tag's bin falls by one at the same edge. The bin counts then always sum to `DEPTH`.
- R5: When the accepted tag and the removed tag address the same bin, that bin's count is unchanged.
- R6: `duty_count` equals the number of tags in the window whose top bit (bit `TAG_W-1`) is 1.
- R7: While `enable` is low, `tag_valid` is ignored and every output holds its value. A tag offered during that time never enters the window.
- R8: A cycle with `tag_valid` low changes no output.
- R9: A single bin can reach the count `DEPTH` without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High: estimates follow new tags; low: estimates frozen |
| tag_valid | input | 1 | A tag is offered this cycle |
| tag | input | TAG_W | Line-select bit followed by the fine code |
| bin_counts | output | (1<<TAG_W)·CNT_W | All bin counts, bin 0 in the least significant slice |
| duty_count | output | CNT_W | Number of window tags whose select bit is set |
| window_full | output | 1 | The window holds `DEPTH` tags |

## Verification
The bench builds the block with `DEPTH = 16` and the default `TAG_W = 8`. A window that short fills within a few cycles, so the first pop, a wrap of the circular buffer and a single bin holding the whole window are all cheap to reach. Many full-window replacements also fit inside a short run. Keeping all 256 bins means the bench can still check both delay-line banks in full and confirm that the duty counter follows only the top tag bit.

// File: rtl/tdc_bin_window_pkg.sv
package tdc_bin_window_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } cnt_step_e;

    function automatic cnt_step_e step_of(input logic up, input logic down);
        if (up && !down)      return STEP_UP;
        else if (down && !up) return STEP_DOWN;
        else                  return STEP_HOLD;
    endfunction

endpackage

// File: rtl/tdc_win_counter.sv
module tdc_win_counter
    import tdc_bin_window_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             down,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cnt_step_e  step;

    always_comb begin
        step = step_of(up, down);
        st_d = st_q;
        case (step)
            STEP_UP:   st_d.count = st_q.count + 1'b1;
            STEP_DOWN: st_d.count = st_q.count - 1'b1;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

endmodule

// File: rtl/tdc_win_fifo.sv
module tdc_win_fifo #(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned DEPTH = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic             pop,
    output logic [TAG_W-1:0] pop_tag,
    output logic             full
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [OCC_W-1:0] occ;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [TAG_W-1:0] mem_q [DEPTH];

    // Once full, the slot about to be overwritten holds the oldest tag.
    assign full    = (st_q.occ == FULL_OCC);
    assign pop     = push && full;
    assign pop_tag = mem_q[st_q.wr_ptr];

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + 1'b1;
            if (!full) st_d.occ = st_q.occ + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wr_ptr] <= push_tag;
    end

endmodule

// File: rtl/tdc_bin_window.sv
module tdc_bin_window #(
    parameter int unsigned TAG_W    = 8,
    parameter int unsigned DEPTH    = 1024,
    localparam int unsigned NUM_BINS = 1 << TAG_W,
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      tag_valid,
    input  logic [TAG_W-1:0]          tag,
    output logic [NUM_BINS*CNT_W-1:0] bin_counts,
    output logic [CNT_W-1:0]          duty_count,
    output logic                      window_full
);

    logic             push;
    logic             pop;
    logic [TAG_W-1:0] old_tag;

    assign push = enable && tag_valid;

    tdc_win_fifo #(
        .TAG_W (TAG_W),
        .DEPTH (DEPTH)
    ) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_tag (tag),
        .pop      (pop),
        .pop_tag  (old_tag),
        .full     (window_full)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        logic bin_up, bin_down;
        assign bin_up   = push && (tag == TAG_W'(b));
        assign bin_down = pop  && (old_tag == TAG_W'(b));

        tdc_win_counter #(
            .CNT_W (CNT_W)
        ) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .up    (bin_up),
            .down  (bin_down),
            .count (bin_counts[b*CNT_W +: CNT_W])
        );
    end

    tdc_win_counter #(
        .CNT_W (CNT_W)
    ) i_duty (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (push && tag[TAG_W-1]),
        .down  (pop && old_tag[TAG_W-1]),
        .count (duty_count)
    );

endmodule

// File: rtl/tdc_bin_window_chk.sv
module tdc_bin_window_chk #(
    parameter int unsigned TAG_W = 8,
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned NUM_BINS = 1 << TAG_W,
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
    localparam int unsigned SUM_W    = CNT_W + TAG_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      enable,
    input logic                      tag_valid,
    input logic [NUM_BINS*CNT_W-1:0] bin_counts,
    input logic [CNT_W-1:0]          duty_count,
    input logic                      window_full
);

    logic [SUM_W-1:0] total;

    always_comb begin
        total = '0;
        for (int i = 0; i < NUM_BINS; i++) begin
            total = total + SUM_W'(bin_counts[i*CNT_W +: CNT_W]);
        end
    end

    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tag_valid && !window_full) |=> (total == SUM_W'($past(total) + 1'b1))); // R2
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        window_full |=> window_full); // R3
    AST_NOT_FULL_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        !window_full |-> (total < SUM_W'(DEPTH))); // R3
    AST_FULL_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        window_full |-> (total == SUM_W'(DEPTH))); // R4
    AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(duty_count) <= total); // R6
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(bin_counts) && $stable(duty_count) && $stable(window_full))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid |=> ($stable(bin_counts) && $stable(duty_count) && $stable(window_full))); // R8

endmodule

bind tdc_bin_window tdc_bin_window_chk #(
    .TAG_W (TAG_W),
    .DEPTH (DEPTH)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .tag_valid   (tag_valid),
    .bin_counts  (bin_counts),
    .duty_count  (duty_count),
    .window_full (window_full)
);

// File: tb/test_tdc_bin_window.sv
`timescale 1ns/1ps
module test_tdc_bin_window;

    localparam int TAG_W    = 8;
    localparam int DEPTH    = 16;
    localparam int NUM_BINS = 1 << TAG_W;
    localparam int CNT_W    = $clog2(DEPTH + 1);

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      enable = 1'b0;
    logic                      tag_valid = 1'b0;
    logic [TAG_W-1:0]          tag = '0;
    logic [NUM_BINS*CNT_W-1:0] bin_counts;
    logic [CNT_W-1:0]          duty_count;
    logic                      window_full;

    int checks = 0;
    int errors = 0;

    int exp_bin [NUM_BINS];
    int exp_duty;
    int win_q [$];

    always #2.5 clk = ~clk;

    tdc_bin_window #(
        .TAG_W (TAG_W),
        .DEPTH (DEPTH)
    ) i_tdc_bin_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tag_valid   (tag_valid),
        .tag         (tag),
        .bin_counts  (bin_counts),
        .duty_count  (duty_count),
        .window_full (window_full)
    );

    function automatic int get_bin(input int b);
        return int'(bin_counts[b*CNT_W +: CNT_W]);
    endfunction

    task automatic model_clear();
        for (int b = 0; b < NUM_BINS; b++) exp_bin[b] = 0;
        exp_duty = 0;
        win_q.delete();
    endtask

    task automatic model_push(input int t);
        int old;
        win_q.push_back(t);
        exp_bin[t]++;
        if (t >= NUM_BINS / 2) exp_duty++;
        if (win_q.size() > DEPTH) begin
            old = win_q.pop_front();
            exp_bin[old]--;
            if (old >= NUM_BINS / 2) exp_duty--;
        end
    endtask

    task automatic check_all(input string req);
        int bad_bin;
        bad_bin = -1;
        checks++;
        if (window_full !== (win_q.size() == DEPTH)) begin
            errors++;
            $display("FAIL %s window_full: actual %0b expected %0b", req, window_full, win_q.size() == DEPTH);
        end
        checks++;
        if (int'(duty_count) != exp_duty) begin
            errors++;
            $display("FAIL %s duty_count: actual %0d expected %0d", req, duty_count, exp_duty);
        end
        checks++;
        for (int b = 0; b < NUM_BINS; b++) begin
            if (bad_bin < 0 && get_bin(b) != exp_bin[b]) bad_bin = b;
        end
        if (bad_bin >= 0) begin
            errors++;
            $display("FAIL %s bin %0d: actual %0d expected %0d", req, bad_bin, get_bin(bad_bin), exp_bin[bad_bin]);
        end
    endtask

    // Drive at the falling edge, let the rising edge act, sample at the next falling edge.
    task automatic step(input logic en, input logic vld, input int t, input string req);
        enable    = en;
        tag_valid = vld;
        tag       = TAG_W'(t);
        @(posedge clk);
        if (en && vld) model_push(t);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b0;
        tag_valid = 1'b0;
        repeat (3) @(negedge clk);
        model_clear();
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        do_reset();

        // R2 R3 R9: fill the window with one tag; it must reach DEPTH without wrap.
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 5, (i == DEPTH - 1) ? "R3 R9" : "R2");
        checks++;
        if (get_bin(5) != DEPTH) begin
            errors++;
            $display("FAIL R9 bin 5: actual %0d expected %0d", get_bin(5), DEPTH);
        end

        // R5: same bin pushed and popped leaves it unchanged.
        step(1'b1, 1'b1, 5, "R5");
        step(1'b1, 1'b1, 5, "R5");

        // R4: replace with the other delay line, one tag at a time.
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 200, "R4 R6");

        // R8: idle cycles with a changing tag.
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, i * 37, "R8");

        // R7: disabled, valid tags are dropped.
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 9 + i, "R7");
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 200, "R7");

        // Partial fill after reset: window_full must stay low.
        do_reset();
        for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 1'b1, 128 + i, "R3 R6");

        // Constrained random mix.
        for (int i = 0; i < 1500; i++) begin
            int t;
            logic en, vld;
            en  = ($urandom_range(0, 7) != 0);
            vld = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 3) == 0) t = $urandom_range(0, 3) + 126;
            else                           t = $urandom_range(0, NUM_BINS - 1);
            step(en, vld, t, "R4 R5 R6 R7 R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule